// File: doc/BRIEF.md
# E1 National-Bit Receive Data Link Extractor

This block picks the national bits out of an HDB3-decoded E1 receive stream and hands them to an external data link controller. The decoded stream is repeated, bit for bit, on a data link output. A second output, the data link strobe, marks the cells that belong to the data link. These are the national bits in positions Sa4 to Sa8 of timeslot zero in non-alignment frames, and only those whose two-bit select code enables pin access.

Every register runs on the recovered receive clock, which toggles at twice the line bit rate. One bit cell is therefore two clock cycles: a first half and a second half. A frame start pulse, one cycle ahead of the first half of bit 0, fixes the bit position. The stream never passes through a slip buffer, so a receive slip cannot drop or repeat a data link bit. The strobe takes one of two forms. In clock mode it is a gapped clock: one high pulse, half a bit cell wide, whose rising edge falls in the middle of the output cell. In enable mode it is an active-low enable that covers the whole cell.

Top module: `rxdl_extract`

## Requirements
- R1: During and after reset, and before any frame activity, `rx_dl` is 0. `rx_dlc` shows its inactive level: 0 in clock mode (`enable_mode`=0) and 1 in enable mode (`enable_mode`=1).
- R2: `rx_dl` carries every decoded bit, including bits that are not selected. It takes the value of `rx_data` one clock after the first half of the input cell, which is mid-cell in bit-rate terms, and holds it for two clocks.
- R3: In clock mode, each selected cell produces exactly one `rx_dlc` high pulse, one clock wide. The pulse rises one clock after `rx_dl` takes that cell's bit, which is the middle of the output cell.
- R4: In enable mode, `rx_dlc` is low for exactly the two clocks in which `rx_dl` holds a selected bit. Adjacent selected bits give one unbroken low stretch.
- R5: Bits 3 to 7 of the frame (0-based, first transmitted bit is 0) are Sa4 to Sa8. Sa(4+i) uses `sa_codes[2i+1:2i]`. Only the code 01 selects the bit. The codes 00, 10 and 11 produce no strobe.
- R6: No strobe is produced for a frame in which `nfas_frame` is 0.
- R7: No strobe is produced while `align_ok` is 0.
- R8: After reset, no strobe is produced until the first `frame_sync` pulse.
- R9: A `frame_sync` pulse makes the next clock the first half of bit 0, even when it arrives in the middle of a frame.
- R10: Each frame yields exactly one strobe per selected Sa bit, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk2x | input | 1 | Recovered receive clock, twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Decoded receive bit, held for both halves of its cell |
| frame_sync | input | 1 | One-clock pulse ahead of the first half of bit 0 |
| nfas_frame | input | 1 | High during a non-alignment frame |
| align_ok | input | 1 | High while receive frame alignment is valid |
| sa_codes | input | 10 | Two-bit select code per Sa bit, Sa4 in bits 1:0 |
| enable_mode | input | 1 | 0: gapped clock strobe, 1: active-low enable strobe |
| rx_dl | output | 1 | Data link output, the full decoded stream |
| rx_dlc | output | 1 | Data link strobe |

## Verification
The bench feeds a pseudo-random bit stream and runs the selection under several code mixes. It uses all codes at 01 to show adjacent cells, and a mix of 01, 00, 10 and 11 to show that only 01 counts. Each mix runs in both strobe forms, which shows the difference between a half-cell pulse and a full-cell enable. Frames with `nfas_frame` low, with alignment lost, and before the first frame pulse test the three gating conditions separately. A frame cut short by an early `frame_sync` is followed by a full frame, which checks that the bit position restarts at the pulse.

// File: rtl/rxdl_pkg.sv
package rxdl_pkg;

  // True when frame bit idx is one of the count Sa cells starting at
  // bit first and its two-bit code field reads 01.
  function automatic logic sa_pick(input int idx, input int first,
                                   input int count, input logic [31:0] codes);
    logic [1:0] fld;
    if (idx < first || idx >= first + count) return 1'b0;
    fld = codes[2*(idx-first) +: 2];
    return fld == 2'b01;
  endfunction

endpackage

// File: rtl/rxdl_position.sv
module rxdl_position #(
  parameter int FRAME_BITS = 256,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic          rclk2x,
  input  logic          rst_n,
  input  logic          frame_sync,
  output logic [CW-1:0] bit_idx,
  output logic          half,
  output logic          synced
);

  always_ff @(posedge rclk2x or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      half    <= 1'b0;
      synced  <= 1'b0;
    end else if (frame_sync) begin
      bit_idx <= '0;
      half    <= 1'b0;
      synced  <= 1'b1;
    end else if (half) begin
      half    <= 1'b0;
      bit_idx <= (bit_idx == CW'(FRAME_BITS - 1)) ? '0 : bit_idx + 1'b1;
    end else begin
      half    <= 1'b1;
    end
  end

endmodule

// File: rtl/rxdl_strobe.sv
module rxdl_strobe #(
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = 3,
  parameter int SA_COUNT   = 5,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic                  rclk2x,
  input  logic                  rst_n,
  input  logic [CW-1:0]         bit_idx,
  input  logic                  half,
  input  logic                  synced,
  input  logic                  align_ok,
  input  logic                  nfas_frame,
  input  logic [2*SA_COUNT-1:0] sa_codes,
  output logic                  cell_sel,
  output logic                  clk_pulse,
  output logic                  en_n
);
  import rxdl_pkg::*;

  logic code_hit;

  always_comb begin
    code_hit = sa_pick(int'(bit_idx), SA_FIRST, SA_COUNT, 32'(sa_codes));
    cell_sel = synced & align_ok & nfas_frame & code_hit;
  end

  // Pulse goes high after the second half of a selected input cell,
  // which is the middle of the output cell. Enable spans the whole cell.
  always_ff @(posedge rclk2x or negedge rst_n) begin
    if (!rst_n) begin
      clk_pulse <= 1'b0;
      en_n      <= 1'b1;
    end else begin
      clk_pulse <= half & cell_sel;
      en_n      <= ~cell_sel;
    end
  end

endmodule

// File: rtl/rxdl_extract.sv
module rxdl_extract #(
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = 3,
  parameter int SA_COUNT   = 5,
  localparam int CW = $clog2(FRAME_BITS)
) (
  input  logic                  rclk2x,
  input  logic                  rst_n,
  input  logic                  rx_data,
  input  logic                  frame_sync,
  input  logic                  nfas_frame,
  input  logic                  align_ok,
  input  logic [2*SA_COUNT-1:0] sa_codes,
  input  logic                  enable_mode,
  output logic                  rx_dl,
  output logic                  rx_dlc
);

  logic [CW-1:0] bit_idx;
  logic          half;
  logic          synced;
  logic          cell_sel;
  logic          clk_pulse;
  logic          en_n;

  rxdl_position #(.FRAME_BITS(FRAME_BITS)) i_pos (
    .rclk2x(rclk2x), .rst_n(rst_n), .frame_sync(frame_sync),
    .bit_idx(bit_idx), .half(half), .synced(synced)
  );

  rxdl_strobe #(.FRAME_BITS(FRAME_BITS), .SA_FIRST(SA_FIRST),
                .SA_COUNT(SA_COUNT)) i_stb (
    .rclk2x(rclk2x), .rst_n(rst_n), .bit_idx(bit_idx), .half(half),
    .synced(synced), .align_ok(align_ok), .nfas_frame(nfas_frame),
    .sa_codes(sa_codes), .cell_sel(cell_sel), .clk_pulse(clk_pulse),
    .en_n(en_n)
  );

  // Data is taken at the end of the first half of each cell.
  always_ff @(posedge rclk2x or negedge rst_n) begin
    if (!rst_n)     rx_dl <= 1'b0;
    else if (!half) rx_dl <= rx_data;
  end

  assign rx_dlc = enable_mode ? en_n : clk_pulse;

endmodule

// File: rtl/rxdl_checker.sv
module rxdl_checker (
  input logic rclk2x,
  input logic rst_n,
  input logic half,
  input logic synced,
  input logic cell_sel,
  input logic clk_pulse,
  input logic en_n,
  input logic align_ok,
  input logic nfas_frame,
  input logic rx_dl
);

  // R2
  data_timing_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    (rx_dl != $past(rx_dl)) |-> !$past(half));

  // R3
  pulse_single_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    clk_pulse |=> !clk_pulse);

  // R3
  pulse_origin_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    clk_pulse |-> $past(cell_sel && half));

  // R4
  enable_width_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    $fell(en_n) |=> !en_n);

  // R4
  enable_origin_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    !en_n |-> $past(cell_sel));

  // R6
  nfas_gate_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    !$past(nfas_frame) |-> (en_n && !clk_pulse));

  // R7
  align_gate_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    !$past(align_ok) |-> (en_n && !clk_pulse));

  // R8
  presync_quiet_chk: assert property (@(posedge rclk2x) disable iff (!rst_n)
    !synced |=> (en_n && !clk_pulse));

endmodule

bind rxdl_extract rxdl_checker i_chk (
  .rclk2x(rclk2x), .rst_n(rst_n), .half(half), .synced(synced),
  .cell_sel(cell_sel), .clk_pulse(clk_pulse), .en_n(en_n),
  .align_ok(align_ok), .nfas_frame(nfas_frame), .rx_dl(rx_dl)
);

// File: tb/test_rxdl_extract.sv
module test_rxdl_extract;

  logic       rclk2x = 1'b0;
  logic       rst_n;
  logic       rx_data;
  logic       frame_sync;
  logic       nfas_frame;
  logic       align_ok;
  logic [9:0] sa_codes;
  logic       enable_mode;
  logic       rx_dl;
  logic       rx_dlc;

  int   checks = 0;
  int   errors = 0;
  int   pulses = 0;
  bit   b_sync = 0;
  logic nxt_dl = 1'b0, nxt_clk = 1'b0, nxt_en = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #10 rclk2x = ~rclk2x;

  rxdl_extract i_rxdl_extract (
    .rclk2x(rclk2x), .rst_n(rst_n), .rx_data(rx_data),
    .frame_sync(frame_sync), .nfas_frame(nfas_frame), .align_ok(align_ok),
    .sa_codes(sa_codes), .enable_mode(enable_mode),
    .rx_dl(rx_dl), .rx_dlc(rx_dlc)
  );

  // Bench's own reading of the selection rule (R5..R8).
  function automatic bit wanted(input int b);
    int k;
    if (!b_sync || !align_ok || !nfas_frame) return 0;
    if (b < 3 || b > 7) return 0;
    k = b - 3;
    return ((sa_codes >> (2 * k)) & 10'd3) == 10'd1;
  endfunction

  task automatic check_out(input string tag);
    logic exp_dlc;
    exp_dlc = enable_mode ? nxt_en : nxt_clk;
    checks++;
    if (rx_dl !== nxt_dl || rx_dlc !== exp_dlc) begin
      errors++;
      $display("FAIL %s: rx_dl=%b rx_dlc=%b expected rx_dl=%b rx_dlc=%b at %0t",
               tag, rx_dl, rx_dlc, nxt_dl, exp_dlc, $time);
    end
    if (!enable_mode && rx_dlc === 1'b1) pulses++;
    if (enable_mode && rx_dlc === 1'b0) pulses++;
  endtask

  task automatic step(input int b, input bit h, input bit d, input bit fs,
                      input string tag);
    bit s;
    @(negedge rclk2x);
    check_out(tag);
    rx_data    = d;
    frame_sync = fs;
    s = wanted(b);
    if (!h) nxt_dl = d;
    nxt_clk = h & s;
    nxt_en  = !s;
    if (fs) b_sync = 1;
  endtask

  task automatic run_frame(input int len, input bit nf, input bit al,
                           input logic [9:0] codes, input bit mode,
                           input string tag);
    int exp_cnt;
    bit d;
    nfas_frame  = nf;
    align_ok    = al;
    sa_codes    = codes;
    enable_mode = mode;
    pulses = 0;
    exp_cnt = 0;
    for (int b = 0; b < len; b++) if (wanted(b)) exp_cnt += mode ? 2 : 1;
    for (int b = 0; b < len; b++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      d = lfsr[0];
      step(b, 1'b0, d, 1'b0, tag);
      step(b, 1'b1, d, (b == len - 1), tag);
    end
    checks++;
    if (pulses != exp_cnt) begin
      errors++;
      $display("FAIL R10 (%s): strobe cycles=%0d expected=%0d", tag, pulses, exp_cnt);
    end
  endtask

  task automatic test_reset();
    // R1
    @(negedge rclk2x);
    enable_mode = 1'b0;
    #1 check_out("R1 clock form");
    enable_mode = 1'b1;
    #1 check_out("R1 enable form");
    enable_mode = 1'b0;
  endtask

  task automatic test_presync();
    // R8: everything enabled but no frame pulse yet
    nfas_frame = 1'b1; align_ok = 1'b1; sa_codes = 10'b0101010101;
    pulses = 0;
    for (int i = 0; i < 300; i++) begin
      enable_mode = (i >= 150);
      step(0, 1'b0, 1'b0, 1'b0, "R8");
    end
    checks++;
    if (pulses != 0) begin
      errors++;
      $display("FAIL R8: strobe cycles=%0d expected=0", pulses);
    end
    enable_mode = 1'b0;
    step(255, 1'b1, 1'b0, 1'b1, "R9 first sync");
  endtask

  initial begin
    rst_n = 1'b0; rx_data = 1'b0; frame_sync = 1'b0; nfas_frame = 1'b0;
    align_ok = 1'b0; sa_codes = '0; enable_mode = 1'b0;
    repeat (3) @(negedge rclk2x);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    test_presync();
    run_frame(256, 1, 1, 10'b0101010101, 0, "R2 R3 all selected");
    run_frame(256, 1, 1, 10'b0111100001, 0, "R5 R3 code mix");
    run_frame(256, 1, 1, 10'b0111100001, 1, "R5 R4 code mix");
    run_frame(256, 0, 1, 10'b0101010101, 0, "R6 alignment frame");
    run_frame(256, 1, 0, 10'b0101010101, 1, "R7 alignment lost");
    run_frame(256, 1, 1, 10'b0101010101, 1, "R4 R2 all selected");
    run_frame(100, 1, 1, 10'b0101010101, 0, "R9 short frame");
    run_frame(256, 1, 1, 10'b0101010101, 1, "R9 R4 after realign");
    run_frame(256, 1, 1, 10'b0001000100, 0, "R5 R10 sparse");
    @(negedge rclk2x);
    check_out("R2 R3 tail");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule